// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block collects interrupt source lines into ten vectors and gives each vector one of three priority levels. It tells the CPU which single vector to take next. Each vector's request is the OR of its source lines, and each line can be masked on its own. A per-vector select bit places the vector in its upper class or at the lowest level. The two lowest-numbered vectors use the top level as their upper class. All other vectors use the middle level.

The controller raises `irq` and drives `vec_addr` for the winning request. A request only wins if its level is above the level now being serviced. When the CPU takes the interrupt, it pulses `ack`, and the granted level is recorded as in service. When the handler finishes, it pulses `ret`, which drops the most recent level. Nested service therefore reaches at most three deep. The CPU's own stack handling and the clearing of peripheral flags stay outside this block.

Top module: `vic_arbiter`

## Requirements
- R1: After reset, `cur_lvl` reads 0 (none) and `irq` is low until a request is evaluated.
- R2: When `irq` is high, `vec_addr` equals 3 + 8·n, where n (0 to 9) is the winning vector.
- R3: Level codes are 0 for none, 1 for L, 2 for H and 3 for X. With `lvl_sel[n]` set, vectors 0 and 1 are at level 3 and vectors 2 to 9 are at level 2. With `lvl_sel[n]` clear, a vector is at level 1.
- R4: Among pending vectors that are eligible, one at a higher level wins over one at a lower level.
- R5: Among eligible vectors at the same level, the lowest vector number wins.
- R6: A vector whose level is equal to or below `cur_lvl` is not presented.
- R7: Vector n's request is the OR of `req[3n+k] & src_en[3n+k]` for k = 0 to 2. A source with its enable bit clear has no effect.
- R8: While `gen_en` is low, `irq` stays low. The in-service state is kept unchanged.
- R9: An `ack` while `irq` is high pushes the presented level. `cur_lvl` shows that level from the next cycle. If `ret` is high in the same cycle, the pop is applied first and the push still takes place.
- R10: `ret` removes the most recent level, so `cur_lvl` falls back to the level that was in service before it. `ret` with nothing in service has no effect.
- R11: `ack` while `irq` is low leaves `cur_lvl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 30 | Source request lines, three per vector |
| src_en | input | 30 | Per-source enable mask |
| lvl_sel | input | 10 | Per-vector select: 1 = upper class, 0 = L |
| gen_en | input | 1 | Global interrupt enable |
| ack | input | 1 | CPU accepts the presented vector |
| ret | input | 1 | Return from interrupt |
| irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 20 | Address of the presented vector |
| cur_lvl | output | 2 | Highest level now in service |

## Verification
`irq` and `vec_addr` are combinational in the requests, the selects, the enable and the stored in-service state. They are therefore due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples one nanosecond later. `cur_lvl` changes only at the rising edge that sees `ack` or `ret`. The bench holds a strobe for exactly one rising edge and reads `cur_lvl` at the following falling edge. Expected winners and addresses come from a small bench-side model covering every vector pair, under all four select combinations and several in-service levels.

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NVEC   = 10,
  parameter int SPV    = 3,
  parameter int NUM_XL = 2,
  parameter int ADDR_W = 20,
  parameter int BASE   = 3,
  parameter int STEP   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NVEC*SPV-1:0]   req,
  input  logic [NVEC*SPV-1:0]   src_en,
  input  logic [NVEC-1:0]       lvl_sel,
  input  logic                  gen_en,
  input  logic                  ack,
  input  logic                  ret,
  output logic                  irq,
  output logic [ADDR_W-1:0]     vec_addr,
  output logic [1:0]            cur_lvl
);
  localparam int IDX_W = $clog2(NVEC);

  logic [NVEC-1:0]  vreq;
  logic [1:0]       vlvl [NVEC];
  logic [2:0]       isr, isr_nxt, top_bit, grant_bit;
  logic [1:0]       win_lvl;
  logic [IDX_W-1:0] win_idx;
  logic             found;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    assign vreq[v] = |(req[v*SPV +: SPV] & src_en[v*SPV +: SPV]);
    if (v < NUM_XL) begin : g_xl
      assign vlvl[v] = lvl_sel[v] ? 2'd3 : 2'd1;
    end else begin : g_hl
      assign vlvl[v] = lvl_sel[v] ? 2'd2 : 2'd1;
    end
  end

  assign cur_lvl = isr[2] ? 2'd3 : isr[1] ? 2'd2 : isr[0] ? 2'd1 : 2'd0;

  always_comb begin
    found   = 1'b0;
    win_lvl = 2'd0;
    win_idx = '0;
    for (int v = NVEC-1; v >= 0; v--) begin
      if (vreq[v] && vlvl[v] > cur_lvl && vlvl[v] >= win_lvl) begin
        found   = 1'b1;
        win_lvl = vlvl[v];
        win_idx = IDX_W'(v);
      end
    end
  end

  assign irq      = gen_en & found;
  assign vec_addr = ADDR_W'(BASE) + ADDR_W'(win_idx) * ADDR_W'(STEP);

  assign top_bit   = isr[2] ? 3'b100 : isr[1] ? 3'b010 : isr[0] ? 3'b001 : 3'b000;
  assign grant_bit = (ack && irq) ? (3'b001 << (win_lvl - 2'd1)) : 3'b000;
  assign isr_nxt   = ((ret ? (isr & ~top_bit) : isr)) | grant_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_nxt;
  end

  p_reset_none_r1: assert property (@(posedge clk) !rst_n |=> cur_lvl == 2'd0);
  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> vec_addr[2:0] == 3'(BASE));
  p_above_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> win_lvl > cur_lvl);
  p_no_req_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !irq);
  p_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !ret) |=> cur_lvl == $past(win_lvl));
  p_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && cur_lvl != 2'd0) |=> cur_lvl < $past(cur_lvl));
  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !ret) |=> $stable(cur_lvl));
endmodule

// File: tb/test_vic_arbiter.sv
module test_vic_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] req = '0, src_en = '0;
  logic [9:0]  lvl_sel = '0;
  logic        gen_en = 1'b0, ack = 1'b0, ret = 1'b0;
  logic        irq;
  logic [19:0] vec_addr;
  logic [1:0]  cur_lvl;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  vic_arbiter i_vic_arbiter (.clk, .rst_n, .req, .src_en, .lvl_sel, .gen_en,
    .ack, .ret, .irq, .vec_addr, .cur_lvl);

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int lvl_of(int v, logic s);
    return s ? (v < 2 ? 3 : 2) : 1;
  endfunction

  function automatic int pick(logic [9:0] m, logic [9:0] s, int cur);
    int best = -1, bl = 0;
    for (int v = 0; v < 10; v++)
      if (m[v] && lvl_of(v, s[v]) > cur && lvl_of(v, s[v]) > bl) begin
        best = v; bl = lvl_of(v, s[v]);
      end
    return best;
  endfunction

  task automatic drive(logic [9:0] m);
    @(negedge clk);
    req = '0;
    for (int v = 0; v < 10; v++) if (m[v]) req[v*3 + (v % 3)] = 1'b1;
    #1;
  endtask

  task automatic expect_out(string r, logic [9:0] m, int cur);
    int p = pick(m, lvl_sel, cur);
    chk(r, int'(irq), int'(p >= 0));
    if (p >= 0) chk(r, int'(vec_addr), 3 + 8 * p);
  endtask

  task automatic strobe(logic a, logic r);
    @(negedge clk); ack = a; ret = r;
    @(negedge clk); ack = 1'b0; ret = 1'b0;
    #1;
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq", int'(irq), 0);
    chk("R1 cur_lvl", int'(cur_lvl), 0);
    rst_n = 1'b1; src_en = '1; gen_en = 1'b1;

    // R2 R3 R4 R5: all pairs under all select combinations
    for (int i = 0; i < 10; i++)
      for (int j = i; j < 10; j++)
        for (int s = 0; s < 4; s++) begin
          lvl_sel = '0;
          lvl_sel[i] = s[0]; lvl_sel[j] = s[1];
          drive(10'(1 << i) | 10'(1 << j));
          expect_out("R4/R5 pair", 10'(1 << i) | 10'(1 << j), 0);
        end

    // R3 R9 R6 R10: push each level, then sweep singles against it
    for (int v = 0; v < 10; v++)
      for (int s = 0; s < 2; s++) begin
        lvl_sel = '0; lvl_sel[v] = 1'(s);
        drive(10'(1 << v));
        strobe(1'b1, 1'b0);
        chk("R3/R9 pushed level", int'(cur_lvl), lvl_of(v, 1'(s)));
        for (int u = 0; u < 10; u++)
          for (int t = 0; t < 2; t++) begin
            lvl_sel = t ? '1 : '0;
            drive(10'(1 << u));
            expect_out("R6 gate", 10'(1 << u), lvl_of(v, 1'(s)));
          end
        drive('0);
        strobe(1'b0, 1'b1);
        chk("R10 pop", int'(cur_lvl), 0);
      end

    // R7: masked sources
    lvl_sel = '0;
    for (int v = 0; v < 10; v++)
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        req = '0; req[v*3+k] = 1'b1; src_en = '1; src_en[v*3+k] = 1'b0;
        #1 chk("R7 masked", int'(irq), 0);
        @(negedge clk);
        src_en = '1;
        #1 chk("R7 enabled", int'(vec_addr), 3 + 8 * v);
      end

    // R8: global enable off keeps in-service
    drive(10'b0000100000);
    strobe(1'b1, 1'b0);
    drive(10'b0000000001); lvl_sel = 10'b1;
    @(negedge clk); gen_en = 1'b0;
    #1 chk("R8 irq off", int'(irq), 0);
    repeat (3) @(negedge clk);
    chk("R8 kept", int'(cur_lvl), 1);
    gen_en = 1'b1;
    #1 chk("R8 restored", int'(irq), 1);
    drive('0);
    strobe(1'b0, 1'b1);

    // R10 nesting L -> H -> X and back
    lvl_sel = 10'b0001000001;
    drive(10'b0000100000); strobe(1'b1, 1'b0);
    chk("R10 nest L", int'(cur_lvl), 1);
    drive(10'b0001000000); strobe(1'b1, 1'b0);
    chk("R10 nest H", int'(cur_lvl), 2);
    drive(10'b0000000001); strobe(1'b1, 1'b0);
    chk("R10 nest X", int'(cur_lvl), 3);
    drive('0);
    strobe(1'b0, 1'b1); chk("R10 back H", int'(cur_lvl), 2);
    strobe(1'b0, 1'b1); chk("R10 back L", int'(cur_lvl), 1);
    strobe(1'b0, 1'b1); chk("R10 back none", int'(cur_lvl), 0);
    strobe(1'b0, 1'b1); chk("R10 empty pop", int'(cur_lvl), 0);

    // R11: ack with nothing presented
    strobe(1'b1, 1'b0); chk("R11 idle ack", int'(cur_lvl), 0);

    // R9: ack and ret together
    drive(10'b0000100000); strobe(1'b1, 1'b0);
    drive(10'b0001000000);
    strobe(1'b1, 1'b1); chk("R9 ack+ret", int'(cur_lvl), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule